// File: doc/BRIEF.md
# Serial EEPROM Read-Path Slave Model

This block models the slave side of a small two-wire serial EEPROM that holds 256 bytes of 8 bits. It watches SCL and SDA as levels sampled in the system clock domain, as a bit-banged master produces them. It finds START and STOP conditions and counts clock pulses. It shifts in a command byte and then a word address, and acknowledges each by pulling SDA low for one SCL pulse. After the address phase it loads the addressed byte from its array into a data shift register.

Each read therefore spans two transactions. When the next transaction carries a read command (command bit 0 set), the slave presents the loaded byte on SDA, MSB first, during the clock pulses of that transaction's address phase. The slave has one open-drain output, a pull-low request. The resolved line is also given as the wired-AND of the master's drive and that request.

The array content is not writable. It comes from two parameters: each byte is a fixed arithmetic function of its address. Device address matching and programming the array are not part of this block.

Top module: `serial_rom_slave`

## Requirements
- R1: After a synchronous active-low reset, the slave does not pull SDA low. The stored previous SCL and SDA levels start high.
- R2: A fall of SDA while SCL stays high is a START. It restarts the bit count at the first command bit and clears the command byte.
- R3: Before the first START, or whenever the bit count is idle and no acknowledge is pending, SCL pulses are ignored and SDA is never pulled low.
- R4: A bit is taken only on an SCL rising edge when SDA keeps its level across that edge. An SCL rise in the same sample as an SDA change is ignored and does not count.
- R5: After eight command bits, the next SCL rising edge is an acknowledge: SDA is pulled low. The pull stays until the next change of SCL or SDA, and is then released.
- R6: After the command acknowledge, eight address bits are shifted in MSB first. The addressed byte is then loaded into the data register, and the next SCL rising edge is acknowledged as in R5. The bit count then goes idle.
- R7: When command bit 0 is 1 (read), each address-bit rising edge drives the data register's MSB onto SDA (pull low for 0, release for 1), and the register shifts left. When bit 0 is 0 (write), SDA is not pulled during the address bits.
- R8: With the default parameters, array byte a equals (a*37 + 0x5A) mod 256.
- R9: The resolved line output equals the master's SDA level ANDed with the inverse of the slave's pull-low request.
- R10: A STOP (rise of SDA while SCL stays high) releases the pull and leaves the bit count and the command byte as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and state use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level from the master |
| sda_i | input | 1 | Sampled SDA level driven by the master (1 = released) |
| sda_pull_low | output | 1 | 1 while the slave pulls SDA low |
| sda_bus_o | output | 1 | Resolved SDA line, the wired-AND of both drives |

## Verification
The command phase is driven with write and read command bytes. A pulse train without a START checks that idle activity leaves SDA alone. An SCL rise that coincides with an SDA change separates a bit that is counted from one that is dropped: if it were counted, the acknowledge would land one pulse early. A STOP in the middle of a command byte shows whether the count is preserved, since the acknowledge then comes only after the remaining bits. Back-to-back transactions with different addresses and command types show that a byte loaded at the end of one address phase is driven out in the next read, and only then.

// File: rtl/srom_pkg.sv
// Shared types for the serial EEPROM slave model.
// Assumes: bus levels reach the block already synchronised to clk.
package srom_pkg;

    // Bus conditions seen in one system clock sample.
    typedef struct packed {
        logic changed;   // SCL or SDA differs from the stored level
        logic scl_rise;  // SCL low before, high now
        logic start;     // SDA fell while SCL held high
        logic stop;      // SDA rose while SCL held high
        logic steady;    // SDA equal to its stored level
    } bus_ev_t;

endpackage

// File: rtl/srom_bus_sampler.sv
// Keeps the previous SCL/SDA levels and classifies each sample.
// Assumes: scl_i/sda_i are synchronous to clk; the idle bus is high.
module srom_bus_sampler
    import srom_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_prev,
    output logic    sda_prev,
    output bus_ev_t ev
);

    // Store the levels of the last sample; reset to an idle bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_i;
            sda_prev <= sda_i;
        end
    end

    // Decode bus conditions from the current and the stored levels.
    always_comb begin
        ev.changed  = (scl_i != scl_prev) || (sda_i != sda_prev);
        ev.scl_rise = !scl_prev && scl_i;
        ev.start    = scl_prev && scl_i && sda_prev && !sda_i;
        ev.stop     = scl_prev && scl_i && !sda_prev && sda_i;
        ev.steady   = (sda_i == sda_prev);
    end

endmodule

// File: rtl/srom_array.sv
// Read-only byte array whose image is computed from two parameters:
// byte(a) = (a * IMG_STEP + IMG_SEED) truncated to DATA_W bits.
// Assumes: the address is stable while the data is used.
module srom_array #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int IMG_STEP = 37,
    parameter int IMG_SEED = 90
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] image [DEPTH];

    // One constant entry for each address, built from the parameters.
    for (genvar g = 0; g < DEPTH; g++) begin : g_img
        assign image[g] = DATA_W'(g * IMG_STEP + IMG_SEED);
    end

    // Asynchronous read of the selected entry.
    assign rd_data = image[rd_addr];

endmodule

// File: rtl/srom_sequencer.sv
// Bit counter and shift registers of the slave: command phase,
// acknowledge, address phase, byte load and read-data output.
// Assumes: events come from srom_bus_sampler in the same cycle.
module srom_sequencer
    import srom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              sda_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              ack_pend,
    output logic              pull_low
);

    localparam int CMD_END  = 1 + DATA_W;        // count after the last command bit
    localparam int ADDR_END = CMD_END + ADDR_W;  // count after the last address bit

    logic [DATA_W-1:0] cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Address including the bit of this sample; feeds the array read.
    assign rd_addr = {addr_q[ADDR_W-2:0], sda_i};

    // Advance the protocol whenever a bus level changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            ack_pend <= 1'b0;
            pull_low <= 1'b0;
        end else if (ev.changed) begin
            pull_low <= 1'b0;
            if (ev.start || ev.stop) begin
                if (ev.start) begin
                    bit_cnt <= CNT_W'(1);
                    cmd_q   <= '0;
                end
            end else if (bit_cnt == '0 && !ack_pend) begin
                // idle: wait for a START
            end else if (ev.scl_rise) begin
                if (ack_pend) begin
                    pull_low <= 1'b1;
                    ack_pend <= 1'b0;
                end else if (ev.steady) begin
                    if (bit_cnt < CNT_W'(CMD_END)) begin
                        cmd_q   <= {cmd_q[DATA_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                        if (bit_cnt == CNT_W'(CMD_END - 1)) begin
                            ack_pend <= 1'b1;
                        end
                    end else if (bit_cnt < CNT_W'(ADDR_END)) begin
                        if (cmd_q[0]) begin
                            pull_low <= !data_q[DATA_W-1];
                        end
                        addr_q <= rd_addr;
                        if (bit_cnt == CNT_W'(ADDR_END - 1)) begin
                            data_q   <= rd_data;
                            ack_pend <= 1'b1;
                            bit_cnt  <= '0;
                        end else begin
                            data_q  <= {data_q[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/serial_rom_slave.sv
// Top of the serial EEPROM read-path slave: sampler, sequencer and
// parameter-built array, plus the wired-AND of the SDA drives.
// Assumes: scl_i/sda_i are synchronised; sda_pull_low feeds an open drain.
module serial_rom_slave
    import srom_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int IMG_STEP = 37,
    parameter int IMG_SEED = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_low,
    output logic sda_bus_o
);

    localparam int ADDR_END = 1 + DATA_W + ADDR_W;
    localparam int CNT_W    = $clog2(ADDR_END + 1);

    bus_ev_t           ev;
    logic              scl_prev;
    logic              sda_prev;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  bit_cnt;
    logic              ack_pend;

    srom_bus_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_prev (scl_prev),
        .sda_prev (sda_prev),
        .ev       (ev)
    );

    srom_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .sda_i    (sda_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .bit_cnt  (bit_cnt),
        .ack_pend (ack_pend),
        .pull_low (sda_pull_low)
    );

    srom_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IMG_STEP (IMG_STEP),
        .IMG_SEED (IMG_SEED)
    ) u_array (
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Open-drain line: low if either side pulls low.
    assign sda_bus_o = sda_i & !sda_pull_low;

endmodule

// File: rtl/srom_checker.sv
// Protocol properties of serial_rom_slave, attached by bind.
// Assumes: reset is synchronous and active low.
module srom_checker #(
    parameter int CNT_W   = 5,
    parameter int CNT_MAX = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_i,
    input logic             scl_prev,
    input logic             sda_prev,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             ack_pend,
    input logic             sda_pull_low
);

    // R5
    hold_without_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i == scl_prev && sda_i == sda_prev) |=> $stable(sda_pull_low));

    // R5
    pull_starts_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> $past(scl_i && !scl_prev));

    // R2
    start_restarts_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_prev && scl_i && sda_prev && !sda_i) |=> (bit_cnt == CNT_W'(1)));

    // R3
    idle_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == '0 && !ack_pend && (scl_i != scl_prev || sda_i != sda_prev))
        |=> !sda_pull_low);

    // R6
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_MAX));

endmodule

bind serial_rom_slave srom_checker #(
    .CNT_W   (CNT_W),
    .CNT_MAX (ADDR_END - 1)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .scl_prev     (scl_prev),
    .sda_prev     (sda_prev),
    .bit_cnt      (bit_cnt),
    .ack_pend     (ack_pend),
    .sda_pull_low (sda_pull_low)
);

// File: tb/serial_rom_slave_tb.sv
`timescale 1ns/1ps
// Directed bench for serial_rom_slave: one task per scenario.
module serial_rom_slave_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic pull;
    logic bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serial_rom_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda),
        .sda_pull_low (pull),
        .sda_bus_o    (bus)
    );

    // Array image from the requirement (defaults step 37, seed 0x5A).
    function automatic logic [7:0] img(input logic [7:0] a);
        return 8'((a * 37) + 8'h5A);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one bus level pair after a falling edge, let it settle.
    task automatic step(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_cond();
        step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    endtask

    // Eight bits MSB first; expected pull while SCL is high.
    task automatic send_byte(input string tag, input logic [7:0] b,
                             input bit rd, input logic [7:0] rd_exp);
        for (int i = 7; i >= 0; i--) begin
            step(0, b[i]);
            step(1, b[i]);
            chk(tag, pull, rd ? !rd_exp[i] : 1'b0);
            chk({tag, " R9"}, bus, b[i] & !(rd ? !rd_exp[i] : 1'b0));
            step(0, b[i]);
        end
    endtask

    task automatic ack_pulse(input string tag);
        step(0, 1);
        step(1, 1);
        chk({tag, " R5 ack low"}, pull, 1'b1);
        chk({tag, " R9 ack line"}, bus, 1'b0);
        step(0, 1);
        chk({tag, " R5 ack release"}, pull, 1'b0);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pull", pull, 1'b0);
        chk("R9 reset line", bus, 1'b1);
        rst_n = 1'b1;
        step(1, 1);
        chk("R1 after reset", pull, 1'b0);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 10; i++) begin
            step(0, 0);
            step(1, 0);
            chk("R3 idle pulse", pull, 1'b0);
            step(0, 0);
        end
    endtask

    // Write command then address 0x3C: loads img(0x3C), no drive.
    task automatic t_setup();
        start_cond();
        send_byte("R2 cmd write", 8'hA0, 1'b0, 8'h00);
        ack_pulse("R2 cmd");
        send_byte("R7 write addr no drive", 8'h3C, 1'b0, 8'h00);
        ack_pulse("R6 addr");
    endtask

    // Read command: address phase shows img(0x3C), loads img(0xC5).
    task automatic t_read_back();
        start_cond();
        send_byte("R2 cmd read", 8'hA1, 1'b0, 8'h00);
        ack_pulse("R5 cmd");
        send_byte("R7 R8 read 3C", 8'hC5, 1'b1, img(8'h3C));
        ack_pulse("R6 addr");
    endtask

    // SCL rise with SDA change is not a bit.
    task automatic t_glitch();
        start_cond();
        send_byte("R4 pre", 8'hA0, 1'b0, 8'h00);  // placeholder pulses
        start_cond();
        for (int i = 0; i < 3; i++) begin
            step(0, (i != 1));
            step(1, (i != 1));
            step(0, (i != 1));
        end
        step(1, 0);   // rise together with SDA fall: dropped
        step(0, 0);
        for (int i = 0; i < 5; i++) begin
            step(0, (i == 4));
            step(1, (i == 4));
            chk("R4 no early ack", pull, 1'b0);
            step(0, (i == 4));
        end
        ack_pulse("R4 ack after 8 valid");
        send_byte("R7 R8 read C5", 8'h82, 1'b1, img(8'hC5));
        ack_pulse("R6 addr");
    endtask

    // STOP mid-command keeps the count: 3 bits, STOP (adds a 0 bit), 4 bits.
    task automatic t_stop_keep();
        start_cond();
        step(0, 1); step(1, 1); step(0, 1);
        step(0, 0); step(1, 0); step(0, 0);
        step(0, 1); step(1, 1); step(0, 1);
        step(0, 0); step(1, 0);
        step(1, 1);
        chk("R10 stop release", pull, 1'b0);
        step(0, 1);
        for (int i = 0; i < 4; i++) begin
            step(0, (i == 3));
            step(1, (i == 3));
            chk("R10 no early ack", pull, 1'b0);
            step(0, (i == 3));
        end
        ack_pulse("R10 ack after stop");
        send_byte("R10 R7 read 82", 8'h10, 1'b1, img(8'h82));
        ack_pulse("R6 addr");
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_idle();
        t_setup();
        t_read_back();
        t_glitch();
        t_stop_keep();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            summary();
        end
    end

endmodule